// File: doc/BRIEF.md
# Decode-Stage Branch Resolver

This unit decides, while a control-transfer instruction sits in the decode stage of a five-stage pipeline, whether the transfer happens and where fetch goes next. It receives the decoded branch fields, the operand used for the test, and the operand that holds the destination address. In the same cycle it raises a redirect signal, and that signal replaces the normal next-address increment of the fetch stage. The unit also owns the fetch address register.

The architecture has one delay slot. The instruction fetched in the same cycle that the branch is in decode is always completed. The redirect therefore only changes the address fetched on the following cycle.

For the linking form of the branch, the unit records the return address, which is the address just past the delay slot. It carries that address, together with the destination register number, through the execute and memory stages. It presents the pair as a write request when the branch reaches write-back.

Top module: `brres_top`

## Requirements
- R1: While reset is asserted, `fetch_pc` equals the reset address (parameter `RESET_PC`, default 100) and `link_we` is low.
- R2: When `pc_sel` is low in a cycle, `fetch_pc` in the next cycle is the current `fetch_pc` plus 4.
- R3: Test code 1 always redirects. Codes 0, 6 and 7 never redirect.
- R4: Code 2 redirects when the test operand is all zeros. Code 3 redirects when the test operand is not zero.
- R5: Code 4 redirects when the most significant bit of the test operand is 0. Code 5 redirects when that bit is 1.
- R6: `pc_sel` is combinational, asserted in the same cycle as the qualifying decode-stage branch. The next `fetch_pc` then equals `target_val`.
- R7: The fetch address present during the branch's decode cycle (the delay-slot instruction) is unchanged by the redirect. Example: with a taken branch decoded while `fetch_pc` is 112 and a target of 512, the fetch sequence is 112 and then 512.
- R8: With `s2_valid` low (a bubble) or `s2_is_branch` low, `pc_sel` stays low and no link write is produced, whatever the other stage-2 fields hold.
- R9: A valid branch with `s2_is_link` high produces `link_we` high exactly three cycles after its decode cycle, whether or not it redirects. At that point `link_idx` equals `s2_dest`, and `link_data` equals the decode-cycle `fetch_pc` plus 4 (the branch address plus 8).
- R10: A valid branch with `s2_is_link` low produces no link write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s2_valid | input | 1 | Decode stage holds a live instruction |
| s2_is_branch | input | 1 | Decode-stage instruction is a branch |
| s2_is_link | input | 1 | Branch also writes a return address |
| s2_cond | input | 3 | Branch test code |
| s2_dest | input | REG_W (5) | Register number that receives the return address |
| cond_val | input | XLEN (32) | Operand tested by the branch |
| target_val | input | XLEN (32) | Destination address operand |
| pc_sel | output | 1 | Redirect: fetch takes `target_val` next |
| fetch_pc | output | XLEN (32) | Current fetch address |
| link_we | output | 1 | Write-back stage return-address write enable |
| link_idx | output | REG_W (5) | Register number for that write |
| link_data | output | XLEN (32) | Return address to write |

## Verification
The bench builds the unit with its defaults: a 32-bit datapath, 5-bit register numbers, a reset address of 100 and three link stages. These values make the reference program sequence 100, 104, 108, 112, 512 reproducible. They also put the sign bit at bit 31, so all-zero, small positive, most-negative and most-positive test operands can be swept against every one of the eight codes. With three link stages, overlapping linking branches are in flight at the same time, which exercises the return-address pipeline with several entries.

// File: rtl/brres_pkg.sv
package brres_pkg;

  // Branch test codes; the numeric values are decoded bitwise by brres_cond.
  typedef enum logic [2:0] {
    CND_NEVER   = 3'd0,
    CND_ALWAYS  = 3'd1,
    CND_ZERO    = 3'd2,
    CND_NONZERO = 3'd3,
    CND_NONNEG  = 3'd4,
    CND_NEG     = 3'd5,
    CND_RSV6    = 3'd6,
    CND_RSV7    = 3'd7
  } cond_e;

  localparam int unsigned PC_STEP = 4;

endpackage

// File: rtl/brres_cond.sv
module brres_cond #(
  parameter int unsigned XLEN = 32
) (
  input  logic [2:0]      code,
  input  logic [XLEN-1:0] val,
  output logic            take
);

  logic nonzero;
  logic sign;

  always_comb begin
    nonzero = |val;
    sign    = val[XLEN-1];
    // bits 2..1 pick the test group, bit 0 picks the polarity
    unique case (code[2:1])
      2'b00:   take = code[0];
      2'b01:   take = ~(code[0] ^ nonzero);
      2'b10:   take = ~(code[0] ^ sign);
      default: take = 1'b0;
    endcase
  end

endmodule

// File: rtl/brres_fetch_pc.sv
module brres_fetch_pc #(
  parameter int unsigned XLEN     = 32,
  parameter int unsigned RESET_PC = 100
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sel,
  input  logic [XLEN-1:0] target,
  output logic [XLEN-1:0] pc
);

  import brres_pkg::*;

  localparam logic [XLEN-1:0] STEP = XLEN'(PC_STEP);
  localparam logic [XLEN-1:0] RST  = XLEN'(RESET_PC);

  logic [XLEN-1:0] pc_d;
  logic [XLEN-1:0] pc_q;

  always_comb begin
    if (sel) pc_d = target;
    else     pc_d = pc_q + STEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= RST;
    else        pc_q <= pc_d;
  end

  assign pc = pc_q;

  AST_PC_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    sel |=> (pc == $past(target))); // R6

  AST_PC_SEQUENTIAL: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> (pc == $past(pc) + STEP)); // R2

endmodule

// File: rtl/brres_link_pipe.sv
module brres_link_pipe #(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned REG_W = 5,
  parameter int unsigned DEPTH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_we,
  input  logic [REG_W-1:0] in_idx,
  input  logic [XLEN-1:0]  in_data,
  output logic             out_we,
  output logic [REG_W-1:0] out_idx,
  output logic [XLEN-1:0]  out_data
);

  logic             we_q   [DEPTH];
  logic [REG_W-1:0] idx_q  [DEPTH];
  logic [XLEN-1:0]  data_q [DEPTH];
  logic             we_d   [DEPTH];
  logic [REG_W-1:0] idx_d  [DEPTH];
  logic [XLEN-1:0]  data_d [DEPTH];

  for (genvar g = 0; g < int'(DEPTH); g++) begin : g_stage
    logic src_we;
    logic [REG_W-1:0] src_idx;
    logic [XLEN-1:0]  src_data;

    if (g == 0) begin : g_head
      assign src_we   = in_we;
      assign src_idx  = in_idx;
      assign src_data = in_data;
    end else begin : g_body
      assign src_we   = we_q[g-1];
      assign src_idx  = idx_q[g-1];
      assign src_data = data_q[g-1];

      AST_LINK_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        we_q[g-1] |=> we_q[g]); // R9
    end

    // payload only loads when a write travels, valid flag always moves
    always_comb begin
      we_d[g]   = src_we;
      idx_d[g]  = src_we ? src_idx  : idx_q[g];
      data_d[g] = src_we ? src_data : data_q[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        we_q[g]   <= 1'b0;
        idx_q[g]  <= '0;
        data_q[g] <= '0;
      end else begin
        we_q[g]   <= we_d[g];
        idx_q[g]  <= idx_d[g];
        data_q[g] <= data_d[g];
      end
    end
  end

  assign out_we   = we_q[DEPTH-1];
  assign out_idx  = idx_q[DEPTH-1];
  assign out_data = data_q[DEPTH-1];

endmodule

// File: rtl/brres_top.sv
module brres_top #(
  parameter int unsigned XLEN        = 32,
  parameter int unsigned REG_W       = 5,
  parameter int unsigned RESET_PC    = 100,
  parameter int unsigned LINK_STAGES = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s2_valid,
  input  logic             s2_is_branch,
  input  logic             s2_is_link,
  input  logic [2:0]       s2_cond,
  input  logic [REG_W-1:0] s2_dest,
  input  logic [XLEN-1:0]  cond_val,
  input  logic [XLEN-1:0]  target_val,
  output logic             pc_sel,
  output logic [XLEN-1:0]  fetch_pc,
  output logic             link_we,
  output logic [REG_W-1:0] link_idx,
  output logic [XLEN-1:0]  link_data
);

  import brres_pkg::*;

  localparam logic [XLEN-1:0] STEP = XLEN'(PC_STEP);

  logic            cond_take;
  logic            br_live;
  logic            link_req;
  logic [XLEN-1:0] ret_addr;

  brres_cond #(.XLEN(XLEN)) i_cond (
    .code (s2_cond),
    .val  (cond_val),
    .take (cond_take)
  );

  always_comb begin
    br_live  = s2_valid & s2_is_branch;
    pc_sel   = br_live & cond_take;
    link_req = br_live & s2_is_link;
    // fetch_pc points at the delay slot here, so this is branch + 8
    ret_addr = fetch_pc + STEP;
  end

  brres_fetch_pc #(.XLEN(XLEN), .RESET_PC(RESET_PC)) i_fetch (
    .clk    (clk),
    .rst_n  (rst_n),
    .sel    (pc_sel),
    .target (target_val),
    .pc     (fetch_pc)
  );

  brres_link_pipe #(.XLEN(XLEN), .REG_W(REG_W), .DEPTH(LINK_STAGES)) i_link (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_we    (link_req),
    .in_idx   (s2_dest),
    .in_data  (ret_addr),
    .out_we   (link_we),
    .out_idx  (link_idx),
    .out_data (link_data)
  );

  AST_SEL_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    pc_sel |-> (s2_valid && s2_is_branch)); // R8

  AST_NO_TAKE_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
    pc_sel |-> !(s2_cond inside {3'd0, 3'd6, 3'd7})); // R3

  AST_ALWAYS_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_valid && s2_is_branch && s2_cond == 3'd1) |-> pc_sel); // R3

endmodule

// File: tb/test_brres_top.sv
module test_brres_top;

  typedef struct packed {
    logic        we;
    logic [4:0]  idx;
    logic [31:0] data;
  } lent_t;

  logic        clk;
  logic        rst_n;
  logic        s2_valid, s2_is_branch, s2_is_link;
  logic [2:0]  s2_cond;
  logic [4:0]  s2_dest;
  logic [31:0] cond_val, target_val;
  logic        pc_sel;
  logic [31:0] fetch_pc;
  logic        link_we;
  logic [4:0]  link_idx;
  logic [31:0] link_data;

  int errors = 0;
  int checks = 0;
  logic [31:0] model_pc;
  bit          last_taken;
  lent_t       lq[$];

  brres_top i_brres_top (
    .clk(clk), .rst_n(rst_n), .s2_valid(s2_valid), .s2_is_branch(s2_is_branch),
    .s2_is_link(s2_is_link), .s2_cond(s2_cond), .s2_dest(s2_dest),
    .cond_val(cond_val), .target_val(target_val), .pc_sel(pc_sel),
    .fetch_pc(fetch_pc), .link_we(link_we), .link_idx(link_idx), .link_data(link_data)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic bit ref_take(input logic [2:0] cd, input logic [31:0] v);
    case (cd)
      3'd1:    return 1'b1;
      3'd2:    return v == 32'd0;
      3'd3:    return v != 32'd0;
      3'd4:    return $signed(v) >= 0;
      3'd5:    return $signed(v) < 0;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string code_req(input logic [2:0] cd);
    if (cd == 3'd2 || cd == 3'd3) return "R4";
    if (cd == 3'd4 || cd == 3'd5) return "R5";
    return "R3";
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic br, input logic lk,
                      input logic [2:0] cd, input logic [31:0] cv,
                      input logic [31:0] tv, input logic [4:0] dst,
                      input string req);
    lent_t ent;
    bit exp_sel;
    s2_valid = v; s2_is_branch = br; s2_is_link = lk; s2_cond = cd;
    cond_val = cv; target_val = tv; s2_dest = dst;
    #4;
    exp_sel = v && br && ref_take(cd, cv);
    chk(pc_sel === exp_sel, req, "pc_sel", 32'(pc_sel), 32'(exp_sel));
    chk(fetch_pc === model_pc, last_taken ? "R6" : "R2", "fetch_pc", fetch_pc, model_pc);
    ent = lq[0];
    chk(link_we === ent.we, ent.we ? "R9" : "R10", "link_we", 32'(link_we), 32'(ent.we));
    if (ent.we) begin
      chk(link_idx === ent.idx, "R9", "link_idx", 32'(link_idx), 32'(ent.idx));
      chk(link_data === ent.data, "R9", "link_data", link_data, ent.data);
    end
    @(posedge clk);
    void'(lq.pop_front());
    lq.push_back('{we: v && br && lk, idx: dst, data: model_pc + 32'd4});
    last_taken = exp_sel;
    model_pc = exp_sel ? tv : model_pc + 32'd4;
    @(negedge clk);
  endtask

  initial begin : watchdog
    #(2_000_000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : stim
    logic [31:0] vals [4];
    vals[0] = 32'h0000_0000; vals[1] = 32'h0000_0005;
    vals[2] = 32'h8000_0000; vals[3] = 32'h7fff_ffff;
    rst_n = 1'b0;
    s2_valid = 1'b0; s2_is_branch = 1'b0; s2_is_link = 1'b0;
    s2_cond = 3'd0; s2_dest = '0; cond_val = '0; target_val = '0;
    for (int i = 0; i < 3; i++) lq.push_back('0);
    model_pc = 32'd100; last_taken = 1'b0;
    repeat (2) @(posedge clk);
    #2;
    chk(fetch_pc === 32'd100, "R1", "reset fetch_pc", fetch_pc, 32'd100);
    chk(link_we === 1'b0, "R1", "reset link_we", 32'(link_we), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // R8: bubble carrying a linking always-branch
    step(1'b0, 1'b1, 1'b1, 3'd1, 32'd0, 32'h0000_0800, 5'd3, "R8");
    // R8: live non-branch with an always code
    step(1'b1, 1'b0, 1'b1, 3'd1, 32'd0, 32'h0000_0900, 5'd4, "R8");
    step(1'b1, 1'b0, 1'b0, 3'd0, 32'd0, 32'd0, 5'd0, "R8");
    // R7: linking branch decoded while fetch_pc is 112, target 512
    chk(fetch_pc === 32'd112, "R7", "delay slot fetch", fetch_pc, 32'd112);
    step(1'b1, 1'b1, 1'b1, 3'd1, 32'd0, 32'd512, 5'd9, "R3");
    chk(fetch_pc === 32'd512, "R7", "fetch after slot", fetch_pc, 32'd512);

    // code sweep; every fourth operand carries a link
    for (int c = 0; c < 8; c++) begin
      for (int k = 0; k < 4; k++) begin
        step(1'b1, 1'b1, k == 1, 3'(c), vals[k],
             32'h0000_1000 + 32'(c * 64 + k * 4), 5'(c + k), code_req(3'(c)));
        // non-branch delay-slot filler
        step(1'b1, 1'b0, 1'b0, 3'd0, 32'd0, 32'd0, 5'd0, "R8");
      end
    end

    // R10: untaken and taken branches without link, back to back
    step(1'b1, 1'b1, 1'b0, 3'd1, 32'd0, 32'h0000_2000, 5'd7, "R10");
    step(1'b1, 1'b1, 1'b0, 3'd0, 32'd0, 32'h0000_3000, 5'd7, "R10");
    // R9: back-to-back linking branches, one never-taken
    step(1'b1, 1'b1, 1'b1, 3'd0, 32'd1, 32'h0000_4000, 5'd11, "R9");
    step(1'b1, 1'b1, 1'b1, 3'd5, 32'hffff_fff0, 32'h0000_5000, 5'd12, "R9");
    step(1'b1, 1'b1, 1'b1, 3'd2, 32'd0, 32'h0000_6000, 5'd13, "R9");
    for (int i = 0; i < 5; i++)
      step(1'b0, 1'b0, 1'b0, 3'd0, 32'd0, 32'd0, 5'd0, "R8");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule